// File: doc/BRIEF.md
# Windowed ROM/RAM Memory Module

This block is a 32K x 8 memory module that sits on a 16-bit address bus. Its 32K window starts at 2000h and ends at 9FFFh. The lower half of the window is read-only. It is held in two byte-wide 8K ROM banks whose contents are computed, so no file is loaded. The upper half is writable. It is built from two 8K banks, and each bank pairs two nibble-wide 8K x 4 RAM devices, one for each half of the byte.

Address bits 12..0 go to every device as the offset inside a bank. Bits 15..13 pick one of four bank selects through a one-hot decode. A separate range compare raises the hit flag. A user drives an address with a read enable and takes back a byte. A write enable stores into RAM on the rising clock edge.

A parameter fixes the read timing. Reads are either combinational in the same cycle, or registered with one cycle of latency and a matching valid flag.

Top module: `mm_module`

## Requirements
- R1: `hit` is 1 exactly when the presented address lies in 2000h..9FFFh, including both ends; addresses 1FFFh, A000h, 0000h and FFFFh give 0.
- R2: For an address outside the window no bank select is active, and a read returns 00h.
- R3: ROM bank 0 answers at 2000h..3FFFh and ROM bank 1 at 4000h..5FFFh. With off = address bits 12..0, the byte read is ((off[7:0] + off[12:8]) mod 256) XOR seed, where the seed is 5Ah for bank 0 and C3h for bank 1.
- R4: A write with the address inside a ROM bank changes nothing: every later read of that address still returns the R3 value, and no RAM device is written.
- R5: A RAM write takes effect at the rising clock edge while `we` is 1. Data bits 7:4 go to one nibble device and bits 3:0 to the other, in the same edge, and a read returns the whole byte.
- R6: RAM bank 0 occupies 6000h..7FFFh and RAM bank 1 occupies 8000h..9FFFh. The two banks hold independent data at the same offset, and at most one bank is written per edge.
- R7: At most one of the four bank selects is active at any time.
- R8: With READ_LAT = 0, `rdata` shows the addressed byte in the same cycle that `re` is 1, and `rd_valid` equals `re`. When `re` is 0, `rdata` is 00h.
- R9: With READ_LAT = 1, `rdata`, `hit` and `rd_valid` are registered. They show, one cycle after the edge, the byte, the window flag and the `re` value that were present at that edge. A cycle with `re` = 0 yields `rdata` = 00h and `rd_valid` = 0.
- R10: A read and a write to the same RAM address in the same cycle return the byte stored before the write, in both read modes. The new byte is returned from the next cycle on.
- R11: While `rst_n` is 0, a registered-mode module drives `rdata`, `hit` and `rd_valid` to 0. A combinational-mode module with `re` = 0 drives `rdata` = 00h and `rd_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for RAM writes and registered reads |
| rst_n | input | 1 | Asynchronous active-low reset of the read registers |
| addr | input | 16 | Byte address on the system bus |
| wdata | input | 8 | Write data |
| we | input | 1 | Write enable; acts only inside a RAM bank |
| re | input | 1 | Read enable |
| rdata | output | 8 | Read data; 00h on a miss or when not reading |
| hit | output | 1 | Address falls inside the module window |
| rd_valid | output | 1 | Read data is valid this cycle |

## Verification
Two functions can fall in the same cycle: a RAM write and a read of that same address, and a write aimed at ROM together with a read of it. The bench provokes the first by holding `we` and `re` high on one RAM address with a new byte. It expects the previous byte before the edge from the combinational instance, and after the edge from the registered instance. The next cycle must show the new byte in both. The ROM case is judged by writing 00h into 2000h while reading, then expecting 5Ah both then and later.

// File: rtl/mm_pkg.sv
package mm_pkg;

  parameter int MM_ADDR_W    = 16;
  parameter int MM_DATA_W    = 8;
  parameter int MM_BANK_AW   = 13;
  parameter int MM_BASE_BANK = 1;

  // seed of ROM bank i: 5Ah for bank 0, C3h for bank 1
  function automatic logic [7:0] rom_seed(input int i);
    logic [7:0] mult;
    mult = 8'(i * 153);
    return 8'h5A ^ mult;
  endfunction

  // first address of bank k counted from the bottom of the address space
  function automatic int unsigned bank_base(input int k, input int aw);
    return int'(k) << aw;
  endfunction

endpackage

// File: rtl/mm_decode.sv
module mm_decode
  import mm_pkg::*;
#(
  parameter int ADDR_W    = MM_ADDR_W,
  parameter int BANK_AW   = MM_BANK_AW,
  parameter int BASE_BANK = MM_BASE_BANK,
  parameter int NB        = 4
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  output logic [NB-1:0]      sel,
  output logic               win_hit,
  output logic [BANK_AW-1:0] off
);

  localparam int TOPW = ADDR_W - BANK_AW;
  localparam int unsigned WIN_LO = bank_base(BASE_BANK, BANK_AW);
  localparam int unsigned WIN_HI = bank_base(BASE_BANK + NB, BANK_AW);

  logic [TOPW-1:0] top_bits;
  assign top_bits = addr[ADDR_W-1:BANK_AW];
  assign off      = addr[BANK_AW-1:0];

  generate
    for (genvar i = 0; i < NB; i++) begin : g_sel
      assign sel[i] = (top_bits == TOPW'(BASE_BANK + i));
    end
  endgenerate

  // range compare kept apart from the bank decode
  logic [31:0] addr_w;
  assign addr_w  = 32'(addr);
  assign win_hit = (addr_w >= WIN_LO) && (addr_w < WIN_HI);

  p_onehot_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  p_hit_matches_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit == (|sel));

endmodule

// File: rtl/mm_rom_bank.sv
module mm_rom_bank #(
  parameter int         BANK_AW = 13,
  parameter int         DATA_W  = 8,
  parameter logic [7:0] SEED    = 8'h5A
)(
  input  logic               sel,
  input  logic [BANK_AW-1:0] off,
  output logic [DATA_W-1:0]  q
);

  // content: low offset byte plus upper offset bits, then the bank seed
  function automatic logic [DATA_W-1:0] rom_byte(input logic [BANK_AW-1:0] o);
    logic [7:0] lo_part;
    logic [7:0] hi_part;
    lo_part = o[7:0];
    hi_part = 8'(o[BANK_AW-1:8]);
    return DATA_W'((lo_part + hi_part) ^ SEED);
  endfunction

  assign q = sel ? rom_byte(off) : '0;

endmodule

// File: rtl/mm_ram_nibble.sv
module mm_ram_nibble #(
  parameter int AW = 13,
  parameter int W  = 4
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] a,
  input  logic [W-1:0]  d,
  output logic [W-1:0]  q
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[a] <= d;
  end

  assign q = mem[a];

  p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (mem[$past(a)] == $past(d)));

endmodule

// File: rtl/mm_module.sv
module mm_module
  import mm_pkg::*;
#(
  parameter int ADDR_W    = MM_ADDR_W,
  parameter int DATA_W    = MM_DATA_W,
  parameter int BANK_AW   = MM_BANK_AW,
  parameter int BASE_BANK = MM_BASE_BANK,
  parameter int ROM_BANKS = 2,
  parameter int RAM_BANKS = 2,
  parameter int READ_LAT  = 0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              re,
  output logic [DATA_W-1:0] rdata,
  output logic              hit,
  output logic              rd_valid
);

  localparam int NB    = ROM_BANKS + RAM_BANKS;
  localparam int NIB_W = DATA_W / 2;

  logic [NB-1:0]        bank_sel;
  logic                 win_hit;
  logic [BANK_AW-1:0]   off;
  logic [DATA_W-1:0]    bank_q [NB];
  logic [RAM_BANKS-1:0] ram_we;
  logic [DATA_W-1:0]    rd_comb;
  logic                 rom_hit;

  mm_decode #(
    .ADDR_W(ADDR_W), .BANK_AW(BANK_AW), .BASE_BANK(BASE_BANK), .NB(NB)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .sel(bank_sel), .win_hit(win_hit), .off(off)
  );

  generate
    for (genvar r = 0; r < ROM_BANKS; r++) begin : g_rom
      mm_rom_bank #(
        .BANK_AW(BANK_AW), .DATA_W(DATA_W), .SEED(rom_seed(r))
      ) u_rom (
        .sel(bank_sel[r]), .off(off), .q(bank_q[r])
      );
    end

    for (genvar m = 0; m < RAM_BANKS; m++) begin : g_ram
      localparam int B = ROM_BANKS + m;
      logic [NIB_W-1:0] hi_q;
      logic [NIB_W-1:0] lo_q;

      assign ram_we[m] = we & bank_sel[B];

      mm_ram_nibble #(.AW(BANK_AW), .W(NIB_W)) u_hi (
        .clk(clk), .rst_n(rst_n), .wr(ram_we[m]), .a(off),
        .d(wdata[DATA_W-1:NIB_W]), .q(hi_q)
      );
      mm_ram_nibble #(.AW(BANK_AW), .W(NIB_W)) u_lo (
        .clk(clk), .rst_n(rst_n), .wr(ram_we[m]), .a(off),
        .d(wdata[NIB_W-1:0]), .q(lo_q)
      );

      assign bank_q[B] = bank_sel[B] ? {hi_q, lo_q} : '0;
    end
  endgenerate

  assign rom_hit = |bank_sel[ROM_BANKS-1:0];

  always_comb begin
    rd_comb = '0;
    for (int b = 0; b < NB; b++) rd_comb = rd_comb | bank_q[b];
  end

  generate
    if (READ_LAT == 0) begin : g_comb_rd
      assign rdata    = re ? rd_comb : '0;
      assign hit      = win_hit;
      assign rd_valid = re;
    end else begin : g_reg_rd
      logic [DATA_W-1:0] rdata_q;
      logic              hit_q;
      logic              valid_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rdata_q <= '0;
          hit_q   <= 1'b0;
          valid_q <= 1'b0;
        end else begin
          rdata_q <= re ? rd_comb : '0;
          hit_q   <= win_hit;
          valid_q <= re;
        end
      end

      assign rdata    = rdata_q;
      assign hit      = hit_q;
      assign rd_valid = valid_q;

      p_valid_follows_re_r9: assert property (@(posedge clk) disable iff (!rst_n)
        re |=> rd_valid);

      p_data_one_late_r9: assert property (@(posedge clk) disable iff (!rst_n)
        re |=> (rdata == $past(rd_comb)));
    end
  endgenerate

  p_rom_write_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && rom_hit) |-> (ram_we == '0));

  p_miss_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> (rd_comb == '0));

  p_single_bank_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ram_we));

endmodule

// File: tb/tb_mm_module.sv
module tb_mm_module;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wdata = 8'h00;
  logic        we = 1'b0;
  logic        re = 1'b0;

  logic [7:0]  rdata, rdata_q;
  logic        hit, hit_q;
  logic        rd_valid, rd_valid_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mm_module #(.READ_LAT(0)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we), .re(re),
    .rdata(rdata), .hit(hit), .rd_valid(rd_valid)
  );

  mm_module #(.READ_LAT(1)) dut_q (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we), .re(re),
    .rdata(rdata_q), .hit(hit_q), .rd_valid(rd_valid_q)
  );

  // {address, expected hit, expected byte}; ROM bytes per R3 by hand
  localparam logic [24:0] VEC [10] = '{
    {16'h1FFF, 1'b0, 8'h00},
    {16'h2000, 1'b1, 8'h5A},
    {16'h3FFF, 1'b1, 8'h44},
    {16'h4000, 1'b1, 8'hC3},
    {16'h5FFF, 1'b1, 8'hDD},
    {16'h2345, 1'b1, 8'h12},
    {16'h4ABC, 1'b1, 8'h05},
    {16'hA000, 1'b0, 8'h00},
    {16'h0000, 1'b0, 8'h00},
    {16'hFFFF, 1'b0, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench restatement of the ROM content rule
  function automatic logic [7:0] rom_ref(input logic [15:0] a);
    int o, s;
    o = int'(a) % 8192;
    s = ((o % 256) + (o / 256)) % 256;
    return 8'(s) ^ ((a < 16'h4000) ? 8'h5A : 8'hC3);
  endfunction

  task automatic ram_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1; re = 1'b0;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic comb_read(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; re = 1'b1; we = 1'b0;
    #2;
    chk(tag, rdata, exp);
  endtask

  initial begin
    // reset state (R11)
    re = 1'b1; addr = 16'h2000;
    repeat (2) @(negedge clk);
    chk("R11 reg rdata in reset", rdata_q, 8'h00);
    chk("R11 reg rd_valid in reset", {7'd0, rd_valid_q}, 8'h00);
    chk("R11 reg hit in reset", {7'd0, hit_q}, 8'h00);
    re = 1'b0;
    #1;
    chk("R11 comb rdata idle", rdata, 8'h00);
    chk("R11 comb rd_valid idle", {7'd0, rd_valid}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk: window edges, misses and ROM bytes (R1 R2 R3 R8)
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      addr = VEC[i][24:9]; re = 1'b1;
      #2;
      chk($sformatf("R1 hit @%h", VEC[i][24:9]), {7'd0, hit}, {7'd0, VEC[i][8]});
      chk($sformatf("R2/R3 rdata @%h", VEC[i][24:9]), rdata, VEC[i][7:0]);
      chk("R8 rd_valid follows re", {7'd0, rd_valid}, 8'h01);
    end
    comb_read(16'h5ABC, rom_ref(16'h5ABC), "R3 ROM bank 1 rule");

    // RAM writes with distinct nibbles in each bank (R5 R6)
    ram_write(16'h6000, 8'hA5);
    ram_write(16'h8000, 8'h96);
    ram_write(16'h9FFF, 8'h3C);
    ram_write(16'h7FFF, 8'h5E);
    comb_read(16'h6000, 8'hA5, "R5 readback 6000");
    chk("R1 hit at 6000", {7'd0, hit}, 8'h01);
    comb_read(16'h8000, 8'h96, "R6 bank1 same offset independent");
    comb_read(16'h9FFF, 8'h3C, "R5 readback 9FFF");
    chk("R1 hit at 9FFF", {7'd0, hit}, 8'h01);
    comb_read(16'h7FFF, 8'h5E, "R6 bank0 top");
    chk("R5 upper nibble", {4'd0, rdata[7:4]}, 8'h05);
    chk("R5 lower nibble", {4'd0, rdata[3:0]}, 8'h0E);

    // write and read of one RAM address in the same cycle (R10)
    @(negedge clk);
    addr = 16'h6000; wdata = 8'h0F; we = 1'b1; re = 1'b1;
    #2;
    chk("R10 comb sees old byte before edge", rdata, 8'hA5);
    @(posedge clk); #1;
    chk("R10 reg sees old byte", rdata_q, 8'hA5);
    chk("R5 comb sees new byte after edge", rdata, 8'h0F);
    @(negedge clk);
    we = 1'b0;
    @(posedge clk); #1;
    chk("R10 reg sees new byte next cycle", rdata_q, 8'h0F);

    // write aimed at ROM while reading it (R4)
    @(negedge clk);
    addr = 16'h2000; wdata = 8'h00; we = 1'b1; re = 1'b1;
    #2;
    chk("R4 ROM read during write", rdata, 8'h5A);
    @(negedge clk);
    we = 1'b0;
    #2;
    chk("R4 ROM unchanged after write", rdata, 8'h5A);
    comb_read(16'h6000, 8'h0F, "R4 RAM untouched by ROM write");

    // read enable low (R8)
    @(negedge clk);
    addr = 16'h9FFF; re = 1'b0;
    #2;
    chk("R8 rdata zero when re low", rdata, 8'h00);
    chk("R8 rd_valid low", {7'd0, rd_valid}, 8'h00);

    // registered read timing (R9)
    @(negedge clk);
    addr = 16'h4000; re = 1'b1;
    #2;
    chk("R9 valid not yet", {7'd0, rd_valid_q}, 8'h00);
    @(posedge clk); #1;
    chk("R9 reg rdata after edge", rdata_q, 8'hC3);
    chk("R9 reg rd_valid after edge", {7'd0, rd_valid_q}, 8'h01);
    chk("R9 reg hit after edge", {7'd0, hit_q}, 8'h01);
    @(negedge clk);
    addr = 16'hA000; re = 1'b0;
    @(posedge clk); #1;
    chk("R9 reg rdata idle", rdata_q, 8'h00);
    chk("R9 reg rd_valid idle", {7'd0, rd_valid_q}, 8'h00);
    chk("R9 reg hit miss", {7'd0, hit_q}, 8'h00);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule